// File: doc/BRIEF.md
# Linear image sensor scan logic

This block is the digital sequencer of a 128-pixel linear light sensor. It moves a single start token through a pixel selector on every rising clock edge. The selector is built as two chainable halves of 64 positions each. At any time the block reports which pixel is routed to its half's output, which integrators must be cleared, whether each half drives its output, and when the token leaves each half. The photodiodes, the integrators and the output amplifier are outside the block. The analog path is represented only by an enable and a selected-pixel index per half.

A scan starts when the first half's start input is sampled high at a rising edge. For a continuous 128-pixel readout, the first half's serial output is wired to the second half's start input. The second half's serial output can then flag end of data, or start the next device in a cascade. Driving the second start input on its own reads both halves in parallel. One more edge after the last pixel returns everything to idle. A start request that arrives while a scan is still running is dropped, and the block reports it on an error output.

Top module: `lin_scan_ctrl`

## Requirements
- R1: While rst_n is low, pix_sel, integ_rst, oe_a, oe_b, so_a, so_b and start_err are all 0, without waiting for a clock edge.
- R2: If si_a is sampled high at a rising edge while no pixel is selected, pix_sel[0] is high after that edge. Counting that edge as edge 1, pixel k (0-based) is the only selected bit after edge k+1 when si_b is tied to so_a.
- R3: Within each half (pixels 0..63 and 64..127), at most one pix_sel bit is high. idx_a holds the 0-based number of the selected pixel of the first half, and idx_b the global number (64..127) of the selected pixel of the second half.
- R4: so_a is high exactly while pixel 63 is selected. so_b is high exactly while pixel 127 is selected.
- R5: oe_a is high exactly when a pixel in 0..63 is selected. oe_b is high exactly when a pixel in 64..127 is selected.
- R6: integ_rst[k] is high for exactly the one cycle that follows the edge at which pix_sel[k] went from 1 to 0. At all other times it is low.
- R7: In a chained scan, edge 129 clears pixel 127. After it, pix_sel, oe_a, oe_b, so_a and so_b are all 0, and integ_rst[127] is high.
- R8: si_a has no effect while any pixel is selected. si_b has no effect while a pixel of the second half is selected. A start ignored at an edge makes start_err high for the cycle after that edge. In a chained scan, a start on si_a at edge 129 is ignored and a start at edge 130 is accepted.
- R9: si_b is accepted while the first half is scanning and the second half is idle. Both halves then select one pixel each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock that advances the token |
| rst_n | input | 1 | Asynchronous active-low reset |
| si_a | input | 1 | Start request for the first half |
| si_b | input | 1 | Start request for the second half (normally wired to so_a) |
| pix_sel | output | 128 | Selected pixel, one bit per pixel |
| integ_rst | output | 128 | One-cycle integrator clear strobes, one per pixel |
| oe_a | output | 1 | First half drives its output; low means high impedance |
| oe_b | output | 1 | Second half drives its output; low means high impedance |
| so_a | output | 1 | Token at the last pixel of the first half |
| so_b | output | 1 | Token at the last pixel of the array |
| idx_a | output | 7 | Number of the selected pixel in the first half |
| idx_b | output | 7 | Global number of the selected pixel in the second half |
| start_err | output | 1 | A start request was ignored at the previous edge |

## Verification
The terminating edge and a start request can fall on the same edge. Edge 129 clears pixel 127 and fires its integrator clear, and in the same cycle a start on si_a must be rejected and flagged. The bench presents si_a at edge 129 and again at edge 130. It expects the error flag, the final clear strobe and idle outputs after edge 129, then pixel 0 with no error after edge 130. A second coincidence is a start of the second half during an active first-half scan. The bench provokes it in parallel mode and expects two selected pixels with correct indices, no error, and a flag when either half is re-started while busy.

// File: rtl/lin_scan_pkg.sv
package lin_scan_pkg;
  localparam int unsigned PIX_COUNT = 128;
  localparam int unsigned PIX_IW    = $clog2(PIX_COUNT);
endpackage

// File: rtl/lin_scan_enc.sv
module lin_scan_enc #(
  parameter int unsigned LEN    = 64,
  parameter int unsigned OFFSET = 0,
  parameter int unsigned IDX_W  = 7
) (
  input  logic [LEN-1:0]   sel,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < LEN; i++) begin
      if (sel[i]) idx = idx | IDX_W'(i + OFFSET);
    end
  end
endmodule

// File: rtl/lin_scan_section.sv
module lin_scan_section #(
  parameter int unsigned LEN = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           si,
  input  logic           hold_off,
  output logic [LEN-1:0] sel,
  output logic [LEN-1:0] irst,
  output logic           oe,
  output logic           so,
  output logic           err
);
  logic [LEN-1:0] sel_d;
  logic [LEN-1:0] irst_d;
  logic           take;
  logic           err_d;

  always_comb begin
    take   = si & ~hold_off;
    err_d  = si & hold_off;
    sel_d  = {sel[LEN-2:0], take};
    irst_d = sel & ~sel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= '0;
      irst <= '0;
      err  <= 1'b0;
    end else begin
      sel  <= sel_d;
      irst <= irst_d;
      err  <= err_d;
    end
  end

  assign oe = |sel;
  assign so = sel[LEN-1];

  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  assert_reject_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (si && hold_off) |=> err);
  assert_clear_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irst == ($past(sel) & ~sel)));
  assert_last_leaves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    so |=> (!so && irst[LEN-1]));
endmodule

// File: rtl/lin_scan_ctrl.sv
module lin_scan_ctrl
  import lin_scan_pkg::*;
#(
  parameter int unsigned NUM_PIX = PIX_COUNT,
  parameter int unsigned IDX_W   = $clog2(NUM_PIX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               si_a,
  input  logic               si_b,
  output logic [NUM_PIX-1:0] pix_sel,
  output logic [NUM_PIX-1:0] integ_rst,
  output logic               oe_a,
  output logic               oe_b,
  output logic               so_a,
  output logic               so_b,
  output logic [IDX_W-1:0]   idx_a,
  output logic [IDX_W-1:0]   idx_b,
  output logic               start_err
);
  localparam int unsigned LEN_A = NUM_PIX / 2;
  localparam int unsigned LEN_B = NUM_PIX - LEN_A;

  logic [LEN_A-1:0] sel_a, irst_a;
  logic [LEN_B-1:0] sel_b, irst_b;
  logic             err_a, err_b;
  logic             hold_a, hold_b;

  // first half waits for the whole array; second half only for itself
  assign hold_a = oe_a | oe_b;
  assign hold_b = oe_b;

  lin_scan_section #(.LEN(LEN_A)) u_sec_a (
    .clk(clk), .rst_n(rst_n), .si(si_a), .hold_off(hold_a),
    .sel(sel_a), .irst(irst_a), .oe(oe_a), .so(so_a), .err(err_a)
  );

  lin_scan_section #(.LEN(LEN_B)) u_sec_b (
    .clk(clk), .rst_n(rst_n), .si(si_b), .hold_off(hold_b),
    .sel(sel_b), .irst(irst_b), .oe(oe_b), .so(so_b), .err(err_b)
  );

  lin_scan_enc #(.LEN(LEN_A), .OFFSET(0), .IDX_W(IDX_W)) u_enc_a (
    .sel(sel_a), .idx(idx_a)
  );

  lin_scan_enc #(.LEN(LEN_B), .OFFSET(LEN_A), .IDX_W(IDX_W)) u_enc_b (
    .sel(sel_b), .idx(idx_b)
  );

  assign pix_sel   = {sel_b, sel_a};
  assign integ_rst = {irst_b, irst_a};
  assign start_err = err_a | err_b;

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (si_a && !oe_a && !oe_b) |=> (pix_sel[0] && !start_err));
  assert_handoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (so_a && si_b && !oe_b) |=> (pix_sel[LEN_A] && !oe_a));
  assert_terminate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (so_b && !si_b && !oe_a) |=> (!oe_a && !oe_b && integ_rst[NUM_PIX-1]));
endmodule

// File: tb/test_lin_scan_ctrl.sv
module test_lin_scan_ctrl;
  localparam int NP = 128;

  logic          clk, rst_n, si_a, si_b;
  logic [NP-1:0] pix_sel, integ_rst;
  logic          oe_a, oe_b, so_a, so_b, start_err;
  logic [6:0]    idx_a, idx_b;

  int  errors = 0;
  int  checks = 0;
  bit  chain  = 1'b0;
  bit  done   = 1'b0;

  lin_scan_ctrl i_lin_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .si_a(si_a), .si_b(si_b),
    .pix_sel(pix_sel), .integ_rst(integ_rst), .oe_a(oe_a), .oe_b(oe_b),
    .so_a(so_a), .so_b(so_b), .idx_a(idx_a), .idx_b(idx_b),
    .start_err(start_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [7:0] edge_n;
    logic       si;
    logic [7:0] pix;   // 255: no pixel
    logic [7:0] rst;   // 255: no strobe
    logic       oa, ob, sa, sb, er;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{8'd1,   1'b1, 8'd0,   8'd255, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd2,   1'b1, 8'd1,   8'd0,   1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{8'd3,   1'b0, 8'd2,   8'd1,   1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd40,  1'b0, 8'd39,  8'd38,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd64,  1'b0, 8'd63,  8'd62,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{8'd65,  1'b0, 8'd64,  8'd63,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd66,  1'b0, 8'd65,  8'd64,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd100, 1'b1, 8'd99,  8'd98,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{8'd128, 1'b0, 8'd127, 8'd126, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{8'd129, 1'b1, 8'd255, 8'd127, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{8'd130, 1'b1, 8'd0,   8'd255, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd131, 1'b0, 8'd1,   8'd0,   1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd132, 1'b0, 8'd2,   8'd1,   1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  function automatic logic [NP-1:0] hot(input int n);
    logic [NP-1:0] v = '0;
    if (n < NP) v[n] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [NP-1:0] act,
                     input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic tick(input logic a, input logic b);
    si_a = a;
    si_b = chain ? so_a : b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_check(input string tag);
    chk({tag, " pix_sel"}, pix_sel, '0);
    chk({tag, " integ_rst"}, integ_rst, '0);
    chk({tag, " flags"}, NP'({oe_a, oe_b, so_a, so_b, start_err}), '0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int ptr;
    logic a;
    rst_n = 1'b0; si_a = 1'b0; si_b = 1'b0;
    repeat (3) @(negedge clk);
    idle_check("R1 reset");
    rst_n = 1'b1;

    // table walk: chained scan across the terminating edge
    chain = 1'b1;
    ptr = 0;
    for (int e = 1; e <= 132; e++) begin
      a = (ptr < NV && int'(VEC[ptr].edge_n) == e) ? VEC[ptr].si : 1'b0;
      tick(a, 1'b0);
      if (ptr < NV && int'(VEC[ptr].edge_n) == e) begin
        chk($sformatf("R2 R7 pix_sel edge %0d", e), pix_sel, hot(VEC[ptr].pix));
        chk($sformatf("R6 integ_rst edge %0d", e), integ_rst, hot(VEC[ptr].rst));
        chk($sformatf("R5 oe edge %0d", e), NP'({oe_a, oe_b}),
            NP'({VEC[ptr].oa, VEC[ptr].ob}));
        chk($sformatf("R4 so edge %0d", e), NP'({so_a, so_b}),
            NP'({VEC[ptr].sa, VEC[ptr].sb}));
        chk($sformatf("R8 start_err edge %0d", e), NP'(start_err), NP'(VEC[ptr].er));
        if (VEC[ptr].oa) chk($sformatf("R3 idx_a edge %0d", e), NP'(idx_a), NP'(VEC[ptr].pix));
        if (VEC[ptr].ob) chk($sformatf("R3 idx_b edge %0d", e), NP'(idx_b), NP'(VEC[ptr].pix));
        ptr++;
      end
    end

    // asynchronous reset in the middle of a scan
    tick(1'b0, 1'b0);
    #3 rst_n = 1'b0;
    #2 idle_check("R1 async mid-scan");
    @(negedge clk);
    rst_n = 1'b1;
    chain = 1'b0;

    // parallel halves
    tick(1'b1, 1'b0);
    repeat (9) tick(1'b0, 1'b0);
    chk("R2 pixel 9", pix_sel, hot(9));
    tick(1'b0, 1'b1);
    chk("R9 both selected", pix_sel, hot(10) | hot(64));
    chk("R9 no error", NP'(start_err), '0);
    chk("R9 oe both", NP'({oe_a, oe_b}), NP'(2'b11));
    chk("R3 idx_a parallel", NP'(idx_a), NP'(10));
    chk("R3 idx_b parallel", NP'(idx_b), NP'(64));
    tick(1'b0, 1'b1);
    chk("R8 si_b busy ignored", pix_sel, hot(11) | hot(65));
    chk("R8 si_b busy flag", NP'(start_err), NP'(1));
    tick(1'b1, 1'b0);
    chk("R8 si_a busy ignored", pix_sel, hot(12) | hot(66));
    chk("R8 si_a busy flag", NP'(start_err), NP'(1));
    tick(1'b0, 1'b0);
    chk("R8 flag one cycle", NP'(start_err), '0);
    chk("R6 parallel strobes", integ_rst, hot(12) | hot(66));

    // flush, then start on si_b alone
    repeat (70) tick(1'b0, 1'b0);
    idle_check("R7 flushed");
    tick(1'b0, 1'b1);
    chk("R9 si_b alone", pix_sel, hot(64));
    chk("R5 oe_b alone", NP'({oe_a, oe_b}), NP'(2'b01));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule